// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block sits on the controller side of a four-bank double-data-rate SDRAM and decides when refresh commands go out. A free-running interval counter adds one owed refresh every `REFI_CYC` clock cycles. Owed refreshes build up into a bounded backlog. While anything is owed the block asks the command arbiter for the bus. Once the arbiter grants it and reports every bank precharged, the block drives AUTO REFRESH commands. After each one it holds the bus quiet for the refresh row cycle time.

The block also moves the device into and out of self-refresh through the clock-enable line. Entry is a refresh encoding driven with clock enable low, and it clears the backlog, because the device then refreshes itself. Exit raises clock enable under a NOP. Two separate windows then tell the arbiter when ACTIVE and READ may be issued again. All nanosecond limits are given as parameters and converted to whole cycles, rounding up.

Top module: `refsched_top`

## Requirements
- R1: While reset is held and in the first cycle after it, cke is 1, all four command lines are 1 (deselect), and refReq, refUrgent, holdOff, actBlock and rdBlock are 0.
- R2: Outside self-refresh the owed count rises by exactly one every REFI_CYC cycles, counted from reset. refReq is 1 exactly while the owed count is non-zero.
- R3: The owed count saturates at MAX_POSTPONE (8 by default). refUrgent is 1 exactly while the count equals that limit. A grant held after that point yields the postponed refreshes back to back, and refUrgent drops in the cycle after the first one.
- R4: A refresh (csN=0, rasN=0, casN=0, weN=1, with cke 1 in this and the previous cycle) appears only in the cycle after one in which arbGnt=1, allIdle=1, srReq=0, something was owed, holdOff=0 and actBlock=0. It reduces the owed count by one.
- R5: RFC_CYC = ceil(TRFC_PS/CLK_PS). holdOff is 1 from the refresh cycle through the following RFC_CYC-2 cycles. With the grant held, consecutive refreshes are exactly RFC_CYC cycles apart.
- R6: With srReq=1 under the same grant conditions as R4, self-refresh entry takes priority over owed refreshes. The entry cycle shows the refresh encoding with cke=0. The owed count goes to zero, and while self-refresh lasts cke stays 0 and csN stays 1.
- R7: In the cycle after one in self-refresh with srReq=0, cke returns to 1 with a NOP (csN=0, rasN=casN=weN=1).
- R8: XSA_CYC = ceil(TXSA_PS/CLK_PS). actBlock is 1 for the XSA_CYC-1 cycles that begin with the exit NOP cycle. rdBlock is 1 for the XSR_CYC-1 cycles that begin there. No refresh and no self-refresh entry starts while actBlock is 1.
- R9: The interval counter is held at zero in self-refresh, so the first owed refresh after exit appears REFI_CYC cycles after the exit NOP cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| arbGnt | input | 1 | Arbiter grants the command bus to the scheduler |
| allIdle | input | 1 | Every bank is precharged |
| srReq | input | 1 | Request to enter (1) or leave (0) self-refresh |
| refReq | output | 1 | At least one refresh is owed |
| refUrgent | output | 1 | Backlog full; serve before further read or write |
| holdOff | output | 1 | Refresh recovery window; no other command allowed |
| actBlock | output | 1 | ACTIVE not yet allowed after self-refresh exit |
| rdBlock | output | 1 | READ not yet allowed after self-refresh exit |
| cke | output | 1 | Clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |

## Verification
The assertions take it that the arbiter asserts arbGnt and allIdle together only when all banks really are precharged and no other command is on the bus. They also take it that srReq is a level which the surrounding logic holds until the block has acted on it. The random stimulus draws grant and idle levels independently, so grants without idle banks also occur, and it holds srReq for long stretches so that entry, stay and exit each play out. Directed runs starve the block until the backlog saturates, then drain the backlog in a single burst, and then step through one full self-refresh cycle.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_SELF = 1'b1
  } modeT;

  // control -> datapath strobes, at most one per cycle
  typedef struct packed {
    logic issueRef;
    logic enterSr;
    logic exitSr;
  } strobeT;

  function automatic int cycCeil(input int timePs, input int clkPs);
    return (timePs + clkPs - 1) / clkPs;
  endfunction

endpackage

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   arbGnt,
  input  logic   allIdle,
  input  logic   srReq,
  input  logic   debtZero,
  input  logic   recovering,
  input  logic   exitBusy,
  output modeT   mode,
  output strobeT strobe
);

  modeT modeQ;
  logic canIssue;

  // bus usable only with grant, precharged banks and no open timing window
  assign canIssue = (modeQ == MODE_RUN) && arbGnt && allIdle && !recovering && !exitBusy;

  always_comb begin
    strobe = '0;
    strobe.enterSr  = canIssue && srReq;
    strobe.issueRef = canIssue && !srReq && !debtZero;
    strobe.exitSr   = (modeQ == MODE_SELF) && !srReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_RUN;
    end else if (strobe.enterSr) begin
      modeQ <= MODE_SELF;
    end else if (strobe.exitSr) begin
      modeQ <= MODE_RUN;
    end
  end

  assign mode = modeQ;

  // R6: entry, refresh and exit are mutually exclusive
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.issueRef, strobe.enterSr, strobe.exitSr}));

  // R8: nothing starts while the post-exit window runs
  p_no_start_in_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    exitBusy |-> !strobe.issueRef && !strobe.enterSr);

endmodule

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int REFI_CYC = 1040,
  parameter int MAX_DEBT = 8,
  parameter int RFC_CYC  = 10,
  parameter int XSA_CYC  = 10,
  parameter int XSR_CYC  = 200
) (
  input  logic   clk,
  input  logic   rstN,
  input  modeT   mode,
  input  strobeT strobe,
  output logic   debtZero,
  output logic   debtFull,
  output logic   recovering,
  output logic   exitBusy,
  output logic   readBusy,
  output logic   cke,
  output logic   csN,
  output logic   rasN,
  output logic   casN,
  output logic   weN
);

  localparam int CNT_W  = $clog2(REFI_CYC + 1);
  localparam int DEBT_W = $clog2(MAX_DEBT + 1);
  localparam int RFC_W  = $clog2(RFC_CYC + 1);
  localparam int XSA_W  = $clog2(XSA_CYC + 1);
  localparam int XSR_W  = $clog2(XSR_CYC + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(REFI_CYC - 1);
  localparam logic [DEBT_W-1:0] DEBT_MAX = DEBT_W'(MAX_DEBT);

  logic [CNT_W-1:0]  intervalCnt;
  logic [DEBT_W-1:0] debt;
  logic [RFC_W-1:0]  rfcCnt;
  logic [XSA_W-1:0]  xsaCnt;
  logic [XSR_W-1:0]  xsrCnt;
  logic              tick;
  logic              inSelf;

  assign inSelf = (mode == MODE_SELF);
  assign tick   = !inSelf && !strobe.enterSr && (intervalCnt == CNT_LAST);

  // average-interval counter, parked at zero during self-refresh
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (inSelf || strobe.enterSr || intervalCnt == CNT_LAST) begin
      intervalCnt <= '0;
    end else begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  // owed-refresh backlog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debt <= '0;
    end else if (inSelf || strobe.enterSr) begin
      debt <= '0;
    end else begin
      unique case ({tick, strobe.issueRef})
        2'b10:   if (debt != DEBT_MAX) debt <= debt + 1'b1;
        2'b01:   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  // timing windows, one per limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rfcCnt <= '0;
      xsaCnt <= '0;
      xsrCnt <= '0;
    end else begin
      if (strobe.issueRef)   rfcCnt <= RFC_W'(RFC_CYC - 1);
      else if (rfcCnt != '0) rfcCnt <= rfcCnt - 1'b1;
      if (strobe.exitSr)     xsaCnt <= XSA_W'(XSA_CYC - 1);
      else if (xsaCnt != '0) xsaCnt <= xsaCnt - 1'b1;
      if (strobe.exitSr)     xsrCnt <= XSR_W'(XSR_CYC - 1);
      else if (xsrCnt != '0) xsrCnt <= xsrCnt - 1'b1;
    end
  end

  // registered command lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke  <= 1'b1;
      csN  <= 1'b1;
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
    end else begin
      cke  <= 1'b1;
      csN  <= 1'b1;
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
      if (strobe.issueRef || strobe.enterSr) begin
        csN  <= 1'b0;
        rasN <= 1'b0;
        casN <= 1'b0;
        cke  <= !strobe.enterSr;
      end else if (strobe.exitSr) begin
        csN  <= 1'b0;
      end else if (inSelf) begin
        cke  <= 1'b0;
      end
    end
  end

  assign debtZero   = (debt == '0);
  assign debtFull   = (debt == DEBT_MAX);
  assign recovering = (rfcCnt != '0);
  assign exitBusy   = (xsaCnt != '0);
  assign readBusy   = (xsrCnt != '0);

  // R5: control never issues while the recovery window runs
  p_rfc_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    recovering |-> !strobe.issueRef);

  // R2: the backlog moves by at most one per cycle upward
  p_debt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (debt > $past(debt)) |-> (debt == $past(debt) + 1'b1));

  // R3: the backlog never passes its limit
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    debt <= DEBT_MAX);

endmodule

// File: rtl/refsched_top.sv
module refsched_top
  import refsched_pkg::*;
#(
  parameter int REFI_CYC     = 1040,
  parameter int MAX_POSTPONE = 8,
  parameter int CLK_PS       = 7500,
  parameter int TRFC_PS      = 75000,
  parameter int TXSA_PS      = 75000,
  parameter int XSR_CYC      = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic arbGnt,
  input  logic allIdle,
  input  logic srReq,
  output logic refReq,
  output logic refUrgent,
  output logic holdOff,
  output logic actBlock,
  output logic rdBlock,
  output logic cke,
  output logic csN,
  output logic rasN,
  output logic casN,
  output logic weN
);

  localparam int RFC_CYC = cycCeil(TRFC_PS, CLK_PS);
  localparam int XSA_CYC = cycCeil(TXSA_PS, CLK_PS);

  modeT   mode;
  strobeT strobe;
  logic   debtZero;
  logic   debtFull;
  logic   recovering;
  logic   exitBusy;
  logic   readBusy;

  refsched_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .arbGnt     (arbGnt),
    .allIdle    (allIdle),
    .srReq      (srReq),
    .debtZero   (debtZero),
    .recovering (recovering),
    .exitBusy   (exitBusy),
    .mode       (mode),
    .strobe     (strobe)
  );

  refsched_dp #(
    .REFI_CYC (REFI_CYC),
    .MAX_DEBT (MAX_POSTPONE),
    .RFC_CYC  (RFC_CYC),
    .XSA_CYC  (XSA_CYC),
    .XSR_CYC  (XSR_CYC)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .strobe     (strobe),
    .debtZero   (debtZero),
    .debtFull   (debtFull),
    .recovering (recovering),
    .exitBusy   (exitBusy),
    .readBusy   (readBusy),
    .cke        (cke),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN)
  );

  assign refReq    = !debtZero;
  assign refUrgent = debtFull;
  assign holdOff   = recovering;
  assign actBlock  = exitBusy;
  assign rdBlock   = readBusy;

  // R4: a refresh on the pins was preceded by a granted, idle cycle
  p_ref_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && !casN && weN && cke) |-> $past(arbGnt) && $past(allIdle));

  // R6: clock enable only falls together with the refresh encoding
  p_cke_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> !csN && !rasN && !casN && weN);

  // R7: clock enable only rises under a NOP
  p_cke_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> !csN && rasN && casN && weN);

  generate
    if (XSA_CYC > 1) begin : g_exitWin
      // R8: the ACTIVE and READ windows open with the exit NOP
      p_exit_window_r8: assert property (@(posedge clk) disable iff (!rstN)
        $rose(cke) |-> actBlock && rdBlock);
    end
  endgenerate

endmodule

// File: tb/test_refsched_top.sv
module test_refsched_top;

  localparam int REFI   = 40;
  localparam int MAXP   = 8;
  localparam int CLKPS  = 4000;
  localparam int RFC    = (75000 + CLKPS - 1) / CLKPS;  // 19
  localparam int XSA    = (75000 + CLKPS - 1) / CLKPS;  // 19
  localparam int XSR    = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arbGnt = 1'b0, allIdle = 1'b0, srReq = 1'b0;
  logic refReq, refUrgent, holdOff, actBlock, rdBlock;
  logic cke, csN, rasN, casN, weN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  refsched_top #(
    .REFI_CYC(REFI), .MAX_POSTPONE(MAXP), .CLK_PS(CLKPS),
    .TRFC_PS(75000), .TXSA_PS(75000), .XSR_CYC(XSR)
  ) i_refsched_top (
    .clk(clk), .rstN(rstN), .arbGnt(arbGnt), .allIdle(allIdle), .srReq(srReq),
    .refReq(refReq), .refUrgent(refUrgent), .holdOff(holdOff),
    .actBlock(actBlock), .rdBlock(rdBlock), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN)
  );

  // behavioural expectation, written from the requirements
  bit mSelf;
  int mCnt, mDebt, mRfc, mXsa, mXsr;
  bit mCke, mCs, mRas, mCas, mWe;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      mSelf = 0; mCnt = 0; mDebt = 0; mRfc = 0; mXsa = 0; mXsr = 0;
      mCke = 1; mCs = 1; mRas = 1; mCas = 1; mWe = 1;
    end else begin
      bit can, eSr, iRef, xSr, tick;
      can  = !mSelf && arbGnt && allIdle && mRfc == 0 && mXsa == 0;
      eSr  = can && srReq;
      iRef = can && !srReq && mDebt != 0;
      xSr  = mSelf && !srReq;
      tick = !mSelf && !eSr && mCnt == REFI - 1;
      mCke = 1; mCs = 1; mRas = 1; mCas = 1; mWe = 1;
      if (iRef || eSr) begin mCs = 0; mRas = 0; mCas = 0; mCke = !eSr; end
      else if (xSr) mCs = 0;
      else if (mSelf) mCke = 0;
      if (mSelf || eSr || mCnt == REFI - 1) mCnt = 0; else mCnt = mCnt + 1;
      if (mSelf || eSr) mDebt = 0;
      else if (tick && !iRef) begin if (mDebt < MAXP) mDebt = mDebt + 1; end
      else if (iRef && !tick) mDebt = mDebt - 1;
      if (iRef) mRfc = RFC - 1; else if (mRfc != 0) mRfc = mRfc - 1;
      if (xSr) mXsa = XSA - 1; else if (mXsa != 0) mXsa = mXsa - 1;
      if (xSr) mXsr = XSR - 1; else if (mXsr != 0) mXsr = mXsr - 1;
      if (eSr) mSelf = 1; else if (xSr) mSelf = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic cmpAll();
    chk("R4 csN", csN, mCs);
    chk("R4 rasN", rasN, mRas);
    chk("R4 casN", casN, mCas);
    chk("R4 weN", weN, mWe);
    chk("R6 cke", cke, mCke);
    chk("R2 refReq", refReq, mDebt != 0);
    chk("R3 refUrgent", refUrgent, mDebt == MAXP);
    chk("R5 holdOff", holdOff, mRfc != 0);
    chk("R8 actBlock", actBlock, mXsa != 0);
    chk("R8 rdBlock", rdBlock, mXsr != 0);
  endtask

  task automatic step();
    @(negedge clk);
    cmpAll();
  endtask

  function automatic bit isRef();
    return !csN && !rasN && !casN && weN && cke;
  endfunction

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lastRef, nRef, actCnt, rdCnt, wait0;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1 cke", cke, 1); chk("R1 csN", csN, 1); chk("R1 refReq", refReq, 0);
    chk("R1 refUrgent", refUrgent, 0); chk("R1 holdOff", holdOff, 0);
    chk("R1 actBlock", actBlock, 0); chk("R1 rdBlock", rdBlock, 0);
    rstN = 1'b1;
    step();
    chk("R1 rasN after reset", rasN, 1);

    // R3: starve until the backlog saturates, then keep starving
    repeat (REFI * MAXP + 80) step();
    chk("R3 saturated urgent", refUrgent, 1);
    chk("R2 owed request", refReq, 1);

    // R3/R5: drain as a burst with the grant held
    arbGnt = 1; allIdle = 1;
    nRef = 0; lastRef = 0;
    for (int i = 0; i < RFC * MAXP + 5; i++) begin
      step();
      if (isRef()) begin
        if (nRef == 0) begin
          step();
          chk("R3 urgent drops after first refresh", refUrgent, 0);
          lastRef = cyc - 1;
        end else begin
          chk("R5 burst spacing", cyc - lastRef, RFC);
          lastRef = cyc;
        end
        nRef++;
      end
    end
    chk("R3 burst refreshes in window", nRef >= MAXP, 1);

    // R6: self-refresh entry with grant held
    srReq = 1;
    wait0 = 0;
    for (int i = 0; i < 3 * RFC && cke; i++) step();
    chk("R6 entered self-refresh", cke, 0);
    repeat (50) step();
    chk("R6 no request while self", refReq, 0);
    chk("R6 deselect while self", csN, 1);

    // R7/R8/R9: exit
    arbGnt = 0; srReq = 0;
    step();
    chk("R7 cke rises", cke, 1);
    chk("R7 NOP csN", csN, 0);
    chk("R7 NOP rasN", rasN, 1);
    actCnt = actBlock; rdCnt = rdBlock; wait0 = 0;
    for (int i = 1; i < XSR + 10; i++) begin
      step();
      actCnt += actBlock; rdCnt += rdBlock;
      if (refReq && wait0 == 0) wait0 = i;
    end
    chk("R8 actBlock length", actCnt, XSA - 1);
    chk("R8 rdBlock length", rdCnt, XSR - 1);
    chk("R9 first owed after exit", wait0, REFI);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      arbGnt  = ($urandom_range(0, 1) == 1);
      allIdle = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 299) == 0) srReq = ~srReq;
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule